// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This unit sits on the result side of a vector execution path and watches element results stream past in ascending index order, one per cycle at most. A start pulse hands it the vector length of the instruction, the kind of operation (arithmetic or load) and that instruction's fail-first enable. With fail-first enabled, an arithmetic element whose result is zero counts as a failure. A load element reporting an access fault also counts as a failure. The first failure cuts the vector length down to that element's index, and from there on every element is kept from being written back. Later instructions then run under the shortened length.

Elements arrive on a valid/ready channel (`el_valid`, `el_ready`, `el_idx`, `el_data`, `el_fault`). The producer must hold valid and the payload stable until a cycle in which ready is high; the transfer happens at that clock edge. Ready is high only while a vector is in progress and no start pulse is present. The producer sends exactly as many elements as the loaded length. Elements past a failure are still accepted, so the channel drains, but they are suppressed. `elem_we` is a combinational per-element write strobe during the transfer cycle. `wen_mask` collects one write-enable bit per element index. `vl_out`, `done` and `trap` are plain status outputs with no back-pressure.

Top module: `ffvl_trunc`

## Requirements
- R1: After reset, `el_ready`, `done` and `trap` are low, and `vl_out` and `wen_mask` are zero.
- R2: A start pulse loads `start_vl` into `vl_out` on the next cycle and clears `wen_mask`, `trap` and `done`. A value above MAXVL is clamped to MAXVL. A loaded length of zero raises `done` on the next cycle without accepting any element.
- R3: With `start_ffirst` low, no element is tested: every element is written, `vl_out` keeps the loaded length and `trap` stays low, whether results are zero or faults are flagged.
- R4: In arithmetic mode (`start_mode` = 0) with fail-first set, the first element with a zero `el_data` at index k > 0 sets `vl_out` to k from the next cycle, and that element's `elem_we` is low.
- R5: In arithmetic mode with fail-first set, a zero result at index 0 sets `vl_out` to 0 and does not raise `trap`.
- R6: In load mode (`start_mode` = 1) with fail-first set, the first element with `el_fault` high at index k > 0 sets `vl_out` to k. A zero `el_data` has no effect in load mode.
- R7: In load mode with fail-first set, a fault on element 0 raises `trap`, leaves `vl_out` at the loaded length and writes no element.
- R8: Only the first failure sets the length. Every element after it has `elem_we` low and does not change `vl_out`, even if it also fails.
- R9: When `done` is high, bit i of `wen_mask` is 1 exactly when element i was written, which is when i is below the final `vl_out`. With `trap` set, the mask is all zero.
- R10: `done` rises on the cycle after the element with index (loaded length − 1) is accepted and stays high until the next start pulse. `el_ready` is low whenever no vector is in progress.
- R11: In arithmetic mode `el_fault` is ignored: flagged faults on non-zero results leave `vl_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a vector |
| start_vl | input | VLW | Vector length for the new vector |
| start_mode | input | 1 | 0 = arithmetic zero test, 1 = load fault test |
| start_ffirst | input | 1 | Fail-first enable for the instruction |
| el_valid | input | 1 | Element payload is valid |
| el_ready | output | 1 | Unit accepts an element this cycle |
| el_idx | input | IW | Index of the element |
| el_data | input | DW | Element result |
| el_fault | input | 1 | Element load access fault |
| elem_we | output | 1 | Write-back strobe for the element being transferred |
| vl_out | output | VLW | Current (possibly truncated) vector length |
| wen_mask | output | MAXVL | Per-element write enables collected so far |
| done | output | 1 | Vector finished |
| trap | output | 1 | Load faulted on element 0 |

## Verification
The bench builds the unit with MAXVL = 16 and DW = 16. With this size a full-length run and a clamp of an oversized length (20 down to 16) both take only a few dozen cycles. The whole mask can be checked bit by bit against the expected one. The narrower data path still goes through the lane-wise zero test across two lanes. Bubbles on the element channel are inserted regularly, so the valid/ready rules are exercised along with the truncation cases at index 0, in the middle and past a first failure.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;

  typedef enum logic {
    MODE_ALU  = 1'b0,
    MODE_LOAD = 1'b1
  } ff_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ff_state_e;

  typedef struct packed {
    ff_mode_e mode;
    logic     ffirst;
  } ff_cfg_t;

endpackage

// File: rtl/ffvl_detect.sv
module ffvl_detect
  import ffvl_pkg::*;
#(
  parameter int DW = 64,
  parameter int LW = 8
) (
  input  ff_cfg_t         cfg,
  input  logic [DW-1:0]   data,
  input  logic            fault,
  output logic            fail
);
  localparam int LANES = (DW + LW - 1) / LW;
  localparam int PW    = LANES * LW;

  logic [PW-1:0]    padded;
  logic [LANES-1:0] lane_nz;
  logic             is_zero;

  assign padded = PW'(data);

  // lane-wise non-zero detect keeps the reduction shallow for wide results
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_nz[g] = |padded[g*LW +: LW];
  end

  assign is_zero = ~|lane_nz;

  always_comb begin
    fail = 1'b0;
    if (cfg.ffirst) begin
      unique case (cfg.mode)
        MODE_ALU:  fail = is_zero;
        MODE_LOAD: fail = fault;
        default:   fail = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ffvl_ctrl.sv
module ffvl_ctrl
  import ffvl_pkg::*;
#(
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] start_vl,
  input  ff_cfg_t        start_cfg,
  input  logic           xfer,
  input  logic [IW-1:0]  idx,
  input  logic           fail,
  output ff_cfg_t        cfg,
  output logic           running,
  output logic           failed,
  output logic           done,
  output logic           trap,
  output logic [VLW-1:0] vl
);
  localparam logic [VLW-1:0] VL_MAX = VLW'(MAXVL);

  ff_state_e      state_q;
  logic [VLW-1:0] lim_q;
  logic [VLW-1:0] vl_q;
  logic [VLW-1:0] clamped;
  logic [VLW-1:0] idx_w;
  logic           failed_q;
  logic           trap_q;
  ff_cfg_t        cfg_q;
  logic           last;
  logic           first_fail;
  logic           zero_trap;

  assign clamped    = (start_vl > VL_MAX) ? VL_MAX : start_vl;
  assign idx_w      = VLW'(idx);
  assign last       = (idx_w == lim_q - 1'b1);
  assign first_fail = fail && !failed_q;
  assign zero_trap  = (cfg_q.mode == MODE_LOAD) && (idx_w == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      lim_q    <= '0;
      vl_q     <= '0;
      failed_q <= 1'b0;
      trap_q   <= 1'b0;
      cfg_q    <= '{mode: MODE_ALU, ffirst: 1'b0};
    end else if (start) begin
      cfg_q    <= start_cfg;
      lim_q    <= clamped;
      vl_q     <= clamped;
      failed_q <= 1'b0;
      trap_q   <= 1'b0;
      state_q  <= (clamped == '0) ? ST_DONE : ST_RUN;
    end else if (state_q == ST_RUN && xfer) begin
      if (first_fail) begin
        failed_q <= 1'b1;
        if (zero_trap) trap_q <= 1'b1;
        else           vl_q   <= idx_w;
      end
      if (last) state_q <= ST_DONE;
    end
  end

  assign cfg     = cfg_q;
  assign running = (state_q == ST_RUN);
  assign failed  = failed_q;
  assign done    = (state_q == ST_DONE);
  assign trap    = trap_q;
  assign vl      = vl_q;
endmodule

// File: rtl/ffvl_mask.sv
module ffvl_mask #(
  parameter int MAXVL = 64,
  localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set,
  input  logic [IW-1:0]    idx,
  output logic [MAXVL-1:0] mask
);
  for (genvar i = 0; i < MAXVL; i++) begin : g_bit
    logic hit;
    assign hit = set && (idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask[i] <= 1'b0;
      else if (clr) mask[i] <= 1'b0;
      else if (hit) mask[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/ffvl_trunc.sv
module ffvl_trunc
  import ffvl_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int DW    = 64,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   start_vl,
  input  logic             start_mode,
  input  logic             start_ffirst,
  input  logic             el_valid,
  output logic             el_ready,
  input  logic [IW-1:0]    el_idx,
  input  logic [DW-1:0]    el_data,
  input  logic             el_fault,
  output logic             elem_we,
  output logic [VLW-1:0]   vl_out,
  output logic [MAXVL-1:0] wen_mask,
  output logic             done,
  output logic             trap
);
  ff_cfg_t start_cfg;
  ff_cfg_t cfg;
  logic    running;
  logic    failed;
  logic    fail;
  logic    xfer;

  assign start_cfg = '{mode: ff_mode_e'(start_mode), ffirst: start_ffirst};

  // start has priority over a transfer in the same cycle
  assign el_ready = running && !start;
  assign xfer     = el_valid && el_ready;
  assign elem_we  = xfer && !fail && !failed;

  ffvl_detect #(.DW(DW)) u_detect (
    .cfg   (cfg),
    .data  (el_data),
    .fault (el_fault),
    .fail  (fail)
  );

  ffvl_ctrl #(.MAXVL(MAXVL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_vl  (start_vl),
    .start_cfg (start_cfg),
    .xfer      (xfer),
    .idx       (el_idx),
    .fail      (fail),
    .cfg       (cfg),
    .running   (running),
    .failed    (failed),
    .done      (done),
    .trap      (trap),
    .vl        (vl_out)
  );

  ffvl_mask #(.MAXVL(MAXVL)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .set   (elem_we),
    .idx   (el_idx),
    .mask  (wen_mask)
  );
endmodule

// File: rtl/ffvl_trunc_chk.sv
module ffvl_trunc_chk #(
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [VLW-1:0]   start_vl,
  input logic             el_valid,
  input logic             el_ready,
  input logic             elem_we,
  input logic [VLW-1:0]   vl_out,
  input logic [MAXVL-1:0] wen_mask,
  input logic             done,
  input logic             trap
);
  // R10
  ready_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(el_ready && done));

  // R8
  vl_shrink_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (el_ready && !start) |=> (vl_out <= $past(vl_out)));

  // R9
  mask_below_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trap) |-> ((wen_mask >> vl_out) == '0));

  // R7
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (wen_mask == '0));

  // R2
  empty_vl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_vl == '0) |=> done);

  // R8
  we_needs_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elem_we |-> (el_valid && el_ready));
endmodule

bind ffvl_trunc ffvl_trunc_chk #(.MAXVL(MAXVL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .start_vl (start_vl),
  .el_valid (el_valid),
  .el_ready (el_ready),
  .elem_we  (elem_we),
  .vl_out   (vl_out),
  .wen_mask (wen_mask),
  .done     (done),
  .trap     (trap)
);

// File: tb/tb_ffvl_trunc.sv
`timescale 1ns/1ps
module tb_ffvl_trunc;
  localparam int MAXVL = 16;
  localparam int DW    = 16;
  localparam int VLW   = $clog2(MAXVL + 1);
  localparam int IW    = $clog2(MAXVL);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [VLW-1:0]   start_vl = '0;
  logic             start_mode = 1'b0;
  logic             start_ffirst = 1'b0;
  logic             el_valid = 1'b0;
  logic             el_ready;
  logic [IW-1:0]    el_idx = '0;
  logic [DW-1:0]    el_data = '0;
  logic             el_fault = 1'b0;
  logic             elem_we;
  logic [VLW-1:0]   vl_out;
  logic [MAXVL-1:0] wen_mask;
  logic             done;
  logic             trap;

  ffvl_trunc #(.MAXVL(MAXVL), .DW(DW)) dut (.*);

  always #2 clk = ~clk;

  int    nchk = 0;
  int    nfail = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";
  bit    exp_q[$];

  logic [DW-1:0] sdata [MAXVL];
  logic          sfault[MAXVL];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected write strobe per transferred element
  always @(negedge clk) begin
    if (rst_n && el_valid && el_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected element", el_idx, -1);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(elem_we == e, cur_req, $sformatf("elem_we idx %0d", el_idx), elem_we, e);
      end
    end
  end

  task automatic prep();
    for (int i = 0; i < MAXVL; i++) begin
      sdata[i]  = DW'(i * 37 + 1);
      sfault[i] = 1'b0;
    end
  endtask

  task automatic run_vec(input int vl, input bit mode, input bit ff, input string req);
    int n;
    bit failed;
    bit xtrap;
    int xvl;
    logic [MAXVL-1:0] xmask;
    cur_req = req;
    n = (vl > MAXVL) ? MAXVL : vl;
    xvl = n; failed = 0; xtrap = 0; xmask = '0;
    for (int i = 0; i < n; i++) begin
      bit f;
      bit we;
      f  = ff && (mode ? sfault[i] : (sdata[i] == '0));
      we = !failed && !f;
      if (f && !failed) begin
        failed = 1;
        if (mode && i == 0) xtrap = 1; else xvl = i;
      end
      xmask[i] = we;
      exp_q.push_back(we);
    end
    @(posedge clk); #1;
    start = 1'b1; start_vl = VLW'(vl); start_mode = mode; start_ffirst = ff;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i % 3 == 2) begin
        el_valid = 1'b0;
        @(posedge clk); #1;
      end
      el_valid = 1'b1; el_idx = IW'(i); el_data = sdata[i]; el_fault = sfault[i];
      @(negedge clk);
      while (!el_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    el_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, req, "done", done, 1);
    chk(el_ready == 1'b0, req, "ready after done", el_ready, 0);
    chk(vl_out == VLW'(xvl), req, "vl_out", vl_out, xvl);
    chk(trap == xtrap, req, "trap", trap, xtrap);
    chk(wen_mask == xmask, req, "wen_mask", wen_mask, xmask);
    chk(exp_q.size() == 0, req, "elements left", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(el_ready == 1'b0, "R1", "el_ready", el_ready, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(trap == 1'b0, "R1", "trap", trap, 0);
    chk(vl_out == '0, "R1", "vl_out", vl_out, 0);
    chk(wen_mask == '0, "R1", "wen_mask", wen_mask, 0);

    // R3 fail-first off, zeros present in arithmetic mode
    prep(); sdata[2] = '0; sdata[6] = '0;
    run_vec(8, 1'b0, 1'b0, "R3");
    // R3 fail-first off, load faults present
    prep(); sfault[0] = 1'b1; sfault[4] = 1'b1;
    run_vec(7, 1'b1, 1'b0, "R3");
    // R4 R8 zero at 5, second zero at 9 ignored
    prep(); sdata[5] = '0; sdata[9] = '0;
    run_vec(12, 1'b0, 1'b1, "R4_R8");
    // R5 zero at index 0
    prep(); sdata[0] = '0;
    run_vec(6, 1'b0, 1'b1, "R5");
    // R6 fault at 3, zero data ignored in load mode
    prep(); sfault[3] = 1'b1; sfault[8] = 1'b1; sdata[1] = '0;
    run_vec(10, 1'b1, 1'b1, "R6");
    // R7 fault on element 0
    prep(); sfault[0] = 1'b1;
    run_vec(5, 1'b1, 1'b1, "R7");
    // R11 faults ignored in arithmetic mode
    prep(); sfault[1] = 1'b1; sfault[3] = 1'b1;
    run_vec(9, 1'b0, 1'b1, "R11");
    // R2 empty vector
    prep();
    run_vec(0, 1'b0, 1'b1, "R2");
    // R2 R10 oversized length clamped, full run
    prep();
    run_vec(20, 1'b0, 1'b1, "R2_R10");
    // R9 failure at the last element
    prep(); sdata[MAXVL-1] = '0;
    run_vec(MAXVL, 1'b0, 1'b1, "R9");
    // R10 done holds until next start
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R10", "done held", done, 1);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule